// File: doc/BRIEF.md
# Trap Entry and Privileged Register Unit

This unit sits beside the execute stage of a small processor core and owns the state that trap handling depends on. It holds the trap vector, the exception PC, the bad address, the trap cause, a free-running cycle count and a compare value, plus a three-bit status word. Every memory access the core presents on the access port is screened in the same cycle for misalignment and for falling outside the memory, and a faulting access becomes a trap.

When a trap is taken, whether from a faulting access or from a trap request raised elsewhere in the core, the unit asserts a redirect. The fetch target is the one programmable vector, and handlers tell traps apart by reading the cause register. Privileged move-to and move-from instructions reach the registers through a small numeric index. Reads are combinational and writes take effect at the next clock edge.

Top module: `trap_ctrl`

## Requirements
- R1: `redirect_valid_o` is high exactly in the cycles where a faulting access or `trap_valid_i` is present, and `redirect_pc_o` then equals the trap vector register exactly, with no offset added.
- R2: On a taken trap the cause register loads the trap number and `epc_o` loads `pc_i` at the next edge. A same-cycle index write to the cause register loses to the trap.
- R3: On a taken trap the status word (bit 0 exception enable, bit 1 supervisor, bit 2 previous supervisor) clears bit 0, sets bit 1, and copies the old bit 1 into bit 2. Without a trap the status word holds its value.
- R4: An access is misaligned when `acc_addr_i` AND (size − 1) is nonzero, where size = 1 << `acc_size_i`. A misaligned fetch (`acc_kind_i` = 0) gives cause 0, and any other misaligned access gives cause 4.
- R5: An aligned access faults when the address is at or above MEM_SIZE or when address + size exceeds MEM_SIZE. The cause is 1 for a fetch, 6 for a store (`acc_kind_i` = 2) and 5 for a load (`acc_kind_i` 1 or 3).
- R6: The bad-address register takes the faulting address for fetch and data faults alike. A trap requested through `trap_valid_i` leaves it unchanged.
- R7: Misalignment outranks the bounds fault on one access, and an access fault outranks a same-cycle `trap_valid_i`, whose `trap_num_i` is then discarded.
- R8: Reads by index: 2 returns the bad address, 3 the trap vector, 4 the count, 5 the compare value, 6 the cause (zero-extended), and 8 returns MEM_SIZE >> 12. Every other index reads zero.
- R9: A write to index 3 stores all XLEN bits into the trap vector, with no low bits masked.
- R10: Writes to index 8 and to unassigned indices change no register.
- R11: The count increments by one each cycle, except in a cycle where index 4 is written, when it takes the written value instead.
- R12: After reset the trap vector, exception PC, bad address, cause, count and compare are zero, and the status word is 3'b001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Memory access present this cycle |
| acc_addr_i | input | XLEN | Access byte address |
| acc_size_i | input | 2 | log2 of access size in bytes |
| acc_kind_i | input | 2 | 0 fetch, 1 load, 2 store, 3 load |
| trap_valid_i | input | 1 | Trap request from elsewhere in the core |
| trap_num_i | input | 5 | Trap number for that request |
| pc_i | input | XLEN | PC of the instruction in this stage |
| pcr_we_i | input | 1 | Privileged register write |
| pcr_idx_i | input | 5 | Privileged register index |
| pcr_wdata_i | input | XLEN | Write data |
| pcr_rdata_o | output | XLEN | Read data for `pcr_idx_i` |
| redirect_valid_o | output | 1 | Trap taken, redirect fetch |
| redirect_pc_o | output | XLEN | Fetch target on a trap |
| epc_o | output | XLEN | Exception PC |
| sr_o | output | 3 | Status word {prev supervisor, supervisor, exception enable} |

## Verification
The assertions assume that every input carries a known value while reset is released. They also assume `acc_size_i` and `acc_kind_i` arrive in the same cycle as the address they describe, because fault detection is purely combinational on that cycle's inputs. The stimulus changes all inputs together on the falling edge and holds them through the rising edge. Its random addresses cluster around zero and around the top of memory, so misalignment and the bounds edge both appear often, and same-cycle collisions between an access fault, a trap request and an index write are produced on purpose.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int CAUSE_W = 5;
  localparam int IDX_W   = 5;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_LOAD2 = 2'd3
  } acc_kind_e;

  localparam logic [CAUSE_W-1:0] TC_FETCH_MISALIGN = 5'd0;
  localparam logic [CAUSE_W-1:0] TC_FETCH_FAULT    = 5'd1;
  localparam logic [CAUSE_W-1:0] TC_DATA_MISALIGN  = 5'd4;
  localparam logic [CAUSE_W-1:0] TC_LOAD_FAULT     = 5'd5;
  localparam logic [CAUSE_W-1:0] TC_STORE_FAULT    = 5'd6;

  localparam logic [IDX_W-1:0] PCR_BADADDR = 5'd2;
  localparam logic [IDX_W-1:0] PCR_VEC     = 5'd3;
  localparam logic [IDX_W-1:0] PCR_COUNT   = 5'd4;
  localparam logic [IDX_W-1:0] PCR_CMP     = 5'd5;
  localparam logic [IDX_W-1:0] PCR_CAUSE   = 5'd6;
  localparam logic [IDX_W-1:0] PCR_MEMSZ   = 5'd8;

  typedef struct packed {
    logic ps;
    logic s;
    logic et;
  } status_t;

  localparam status_t SR_RESET = '{ps: 1'b0, s: 1'b0, et: 1'b1};
endpackage

// File: rtl/trap_access_check.sv
module trap_access_check
  import trap_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int unsigned MEM_SIZE = 32'h0001_0000
) (
  input  logic                 valid_i,
  input  logic [XLEN-1:0]      addr_i,
  input  logic [1:0]           size_i,
  input  logic [1:0]           kind_i,
  output logic                 fault_o,
  output logic [CAUSE_W-1:0]   code_o
);
  localparam logic [XLEN:0] MEM_END = (XLEN+1)'(MEM_SIZE);

  logic [XLEN-1:0] nbytes;
  logic [XLEN:0]   end_addr;
  logic            misal, oob, is_fetch;

  assign nbytes   = XLEN'(1) << size_i;
  assign end_addr = {1'b0, addr_i} + {1'b0, nbytes};
  assign misal    = |(addr_i & (nbytes - XLEN'(1)));
  assign oob      = ({1'b0, addr_i} >= MEM_END) || (end_addr > MEM_END);
  assign is_fetch = (acc_kind_e'(kind_i) == ACC_FETCH);

  always_comb begin
    fault_o = valid_i && (misal || oob);
    // alignment outranks bounds
    if (misal)                                 code_o = is_fetch ? TC_FETCH_MISALIGN : TC_DATA_MISALIGN;
    else if (is_fetch)                         code_o = TC_FETCH_FAULT;
    else if (acc_kind_e'(kind_i) == ACC_STORE) code_o = TC_STORE_FAULT;
    else                                       code_o = TC_LOAD_FAULT;
  end
endmodule

// File: rtl/trap_status_reg.sv
module trap_status_reg
  import trap_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    take_i,
  output status_t sr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_o <= SR_RESET;
    else if (take_i) begin
      sr_o.ps <= sr_o.s;
      sr_o.s  <= 1'b1;
      sr_o.et <= 1'b0;
    end
  end
endmodule

// File: rtl/trap_pcr_file.sv
module trap_pcr_file
  import trap_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int unsigned MEM_SIZE = 32'h0001_0000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               take_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic               bad_we_i,
  input  logic [XLEN-1:0]    bad_addr_i,
  input  logic               we_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [XLEN-1:0]    wdata_i,
  output logic [XLEN-1:0]    rdata_o,
  output logic [XLEN-1:0]    evec_o,
  output logic [XLEN-1:0]    epc_o
);
  localparam logic [XLEN-1:0] MEM_PAGES = XLEN'(MEM_SIZE >> 12);

  logic [XLEN-1:0]    bad_q, count_q, cmp_q;
  logic [CAUSE_W-1:0] cause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evec_o  <= '0;
      epc_o   <= '0;
      bad_q   <= '0;
      cause_q <= '0;
      count_q <= '0;
      cmp_q   <= '0;
    end else begin
      if (we_i && idx_i == PCR_VEC) evec_o <= wdata_i;
      if (we_i && idx_i == PCR_CMP) cmp_q  <= wdata_i;
      count_q <= (we_i && idx_i == PCR_COUNT) ? wdata_i : count_q + XLEN'(1);
      if (bad_we_i)                         bad_q <= bad_addr_i;
      else if (we_i && idx_i == PCR_BADADDR) bad_q <= wdata_i;
      // trap entry beats a same-cycle index write
      if (take_i) begin
        cause_q <= cause_i;
        epc_o   <= pc_i;
      end else if (we_i && idx_i == PCR_CAUSE) begin
        cause_q <= wdata_i[CAUSE_W-1:0];
      end
    end
  end

  always_comb begin
    unique case (idx_i)
      PCR_BADADDR: rdata_o = bad_q;
      PCR_VEC:     rdata_o = evec_o;
      PCR_COUNT:   rdata_o = count_q;
      PCR_CMP:     rdata_o = cmp_q;
      PCR_CAUSE:   rdata_o = XLEN'(cause_q);
      PCR_MEMSZ:   rdata_o = MEM_PAGES;
      default:     rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int unsigned MEM_SIZE = 32'h0001_0000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               acc_valid_i,
  input  logic [XLEN-1:0]    acc_addr_i,
  input  logic [1:0]         acc_size_i,
  input  logic [1:0]         acc_kind_i,
  input  logic               trap_valid_i,
  input  logic [CAUSE_W-1:0] trap_num_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic               pcr_we_i,
  input  logic [IDX_W-1:0]   pcr_idx_i,
  input  logic [XLEN-1:0]    pcr_wdata_i,
  output logic [XLEN-1:0]    pcr_rdata_o,
  output logic               redirect_valid_o,
  output logic [XLEN-1:0]    redirect_pc_o,
  output logic [XLEN-1:0]    epc_o,
  output logic [2:0]         sr_o
);
  logic               acc_fault, take;
  logic [CAUSE_W-1:0] acc_code, cause_sel;
  logic [XLEN-1:0]    evec;
  status_t            sr;

  trap_access_check #(.XLEN(XLEN), .MEM_SIZE(MEM_SIZE)) u_chk_acc (
    .valid_i (acc_valid_i),
    .addr_i  (acc_addr_i),
    .size_i  (acc_size_i),
    .kind_i  (acc_kind_i),
    .fault_o (acc_fault),
    .code_o  (acc_code)
  );

  assign take      = acc_fault || trap_valid_i;
  assign cause_sel = acc_fault ? acc_code : trap_num_i;

  trap_status_reg u_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .take_i (take),
    .sr_o   (sr)
  );

  trap_pcr_file #(.XLEN(XLEN), .MEM_SIZE(MEM_SIZE)) u_pcr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_i     (take),
    .cause_i    (cause_sel),
    .pc_i       (pc_i),
    .bad_we_i   (acc_fault),
    .bad_addr_i (acc_addr_i),
    .we_i       (pcr_we_i),
    .idx_i      (pcr_idx_i),
    .wdata_i    (pcr_wdata_i),
    .rdata_o    (pcr_rdata_o),
    .evec_o     (evec),
    .epc_o      (epc_o)
  );

  assign redirect_valid_o = take;
  assign redirect_pc_o    = evec;
  assign sr_o             = sr;
endmodule

// File: rtl/trap_ctrl_chk.sv
module trap_ctrl_chk #(
  parameter int XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            acc_valid_i,
  input logic [XLEN-1:0] acc_addr_i,
  input logic [1:0]      acc_size_i,
  input logic            trap_valid_i,
  input logic [XLEN-1:0] pc_i,
  input logic            pcr_we_i,
  input logic [4:0]      pcr_idx_i,
  input logic [XLEN-1:0] pcr_wdata_i,
  input logic [XLEN-1:0] pcr_rdata_o,
  input logic            redirect_valid_o,
  input logic [XLEN-1:0] epc_o,
  input logic [2:0]      sr_o
);
  logic [XLEN-1:0] size_mask;
  assign size_mask = (XLEN'(1) << acc_size_i) - XLEN'(1);

  p_no_spurious_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_valid_i && !trap_valid_i) |-> !redirect_valid_o);

  p_epc_capture_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_valid_o |=> (epc_o == $past(pc_i)));

  p_status_entry_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_valid_o |=> (sr_o[1] && !sr_o[0] && (sr_o[2] == $past(sr_o[1]))));

  p_status_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !redirect_valid_o |=> $stable(sr_o));

  p_misalign_traps_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && |(acc_addr_i & size_mask)) |-> redirect_valid_o);

  p_count_write_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pcr_we_i && pcr_idx_i == 5'd4) |=>
      (pcr_idx_i != 5'd4 || pcr_rdata_o == $past(pcr_wdata_i)));
endmodule

bind trap_ctrl trap_ctrl_chk #(.XLEN(XLEN)) u_trap_ctrl_chk (.*);

// File: tb/trap_ctrl_bench.sv
module trap_ctrl_bench;
  localparam int          XLEN = 32;
  localparam int unsigned MEM  = 32'h0001_0000;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            acc_valid_i = 1'b0;
  logic [31:0]     acc_addr_i = '0;
  logic [1:0]      acc_size_i = '0;
  logic [1:0]      acc_kind_i = '0;
  logic            trap_valid_i = 1'b0;
  logic [4:0]      trap_num_i = '0;
  logic [31:0]     pc_i = '0;
  logic            pcr_we_i = 1'b0;
  logic [4:0]      pcr_idx_i = '0;
  logic [31:0]     pcr_wdata_i = '0;
  logic [31:0]     pcr_rdata_o;
  logic            redirect_valid_o;
  logic [31:0]     redirect_pc_o;
  logic [31:0]     epc_o;
  logic [2:0]      sr_o;

  trap_ctrl #(.XLEN(XLEN), .MEM_SIZE(MEM)) u_trap_ctrl (.*);

  always #5 clk_i = ~clk_i;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // reference state
  longint unsigned m_vec, m_epc, m_bad, m_cause, m_count, m_cmp;
  bit m_et, m_s, m_ps;

  task automatic mreset();
    m_vec = 0; m_epc = 0; m_bad = 0; m_cause = 0; m_count = 0; m_cmp = 0;
    m_et = 1; m_s = 0; m_ps = 0;
  endtask

  function automatic longint unsigned mread(int idx);
    case (idx)
      2: return m_bad;
      3: return m_vec;
      4: return m_count;
      5: return m_cmp;
      6: return m_cause;
      8: return MEM / 4096;
      default: return 0;
    endcase
  endfunction

  task automatic cmp(string req, string what, longint unsigned act, longint unsigned exp);
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare, update model at posedge
  task automatic step(string req, bit av, longint unsigned addr, int sz, int kind,
                      bit tv, int tnum, longint unsigned pc,
                      bit we, int idx, longint unsigned wd);
    longint unsigned n;
    bit mis, oob, fault, take;
    int code;
    acc_valid_i = av; acc_addr_i = addr[31:0]; acc_size_i = sz[1:0]; acc_kind_i = kind[1:0];
    trap_valid_i = tv; trap_num_i = tnum[4:0]; pc_i = pc[31:0];
    pcr_we_i = we; pcr_idx_i = idx[4:0]; pcr_wdata_i = wd[31:0];
    n = 64'd1 << sz;
    mis = (addr % n) != 0;
    oob = (addr >= MEM) || (addr + n > MEM);
    fault = av && (mis || oob);
    if (mis) code = (kind == 0) ? 0 : 4;
    else if (kind == 0) code = 1;
    else if (kind == 2) code = 6;
    else code = 5;
    take = fault || tv;
    #2;
    vectors++;
    cmp("R1/R7", "redirect_valid", redirect_valid_o, take);
    if (take) cmp("R1", "redirect_pc", redirect_pc_o, m_vec);
    cmp("R3", "status", sr_o, {m_ps, m_s, m_et});
    cmp("R2", "epc", epc_o, m_epc);
    cmp(req, $sformatf("read idx %0d", idx), pcr_rdata_o, mread(idx));
    @(posedge clk_i);
    if (we && idx == 3) m_vec = wd;
    if (we && idx == 5) m_cmp = wd;
    m_count = (we && idx == 4) ? wd : ((m_count + 1) & 64'hFFFF_FFFF);
    if (fault) m_bad = addr;
    else if (we && idx == 2) m_bad = wd;
    if (take) begin
      m_cause = fault ? code : tnum;
      m_epc = pc;
      m_ps = m_s; m_s = 1; m_et = 0;
    end else if (we && idx == 6) m_cause = wd & 31;
    @(negedge clk_i);
  endtask

  task automatic rd(string req, int idx);
    step(req, 0, 0, 0, 0, 0, 0, 0, 0, idx, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    mreset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R12 reset values
    rd("R12", 4); rd("R12", 2); rd("R12", 3); rd("R12", 5); rd("R12", 6);
    // R9 full-width vector write, odd value
    step("R9", 0, 0, 0, 0, 0, 0, 0, 1, 3, 64'h8000_1235);
    rd("R9", 3);
    // R1 R2 R3 R6 external trap
    step("R1", 0, 0, 0, 0, 1, 9, 64'h100, 0, 2, 0);
    rd("R2", 6); rd("R6", 2);
    // R4 misaligned fetch and load
    step("R4", 1, 64'h102, 2, 0, 0, 0, 64'h200, 0, 0, 0);
    rd("R4", 6); rd("R6", 2);
    step("R4", 1, 64'h3, 1, 1, 0, 0, 64'h204, 0, 0, 0);
    rd("R4", 6);
    // R5 bounds for each kind, edge at top of memory
    step("R5", 1, 64'hFFF8, 3, 2, 0, 0, 0, 0, 0, 0);
    step("R5", 1, 64'h10000, 2, 0, 0, 0, 64'h300, 0, 6, 0);
    rd("R5", 6);
    step("R5", 1, 64'h10000, 0, 1, 0, 0, 0, 0, 0, 0);
    rd("R5", 6);
    step("R5", 1, 64'hFFFF_FFFC, 2, 2, 0, 0, 0, 0, 0, 0);
    rd("R5", 6); rd("R6", 2);
    // R7 priorities
    step("R7", 1, 64'h10001, 1, 0, 0, 0, 0, 0, 0, 0);
    rd("R7", 6);
    step("R7", 1, 64'h10000, 0, 2, 1, 17, 0, 0, 0, 0);
    rd("R7", 6);
    // R2 trap beats cause write
    step("R2", 0, 0, 0, 0, 1, 12, 64'h44, 1, 6, 3);
    rd("R2", 6);
    // R8 map reads
    step("R8", 0, 0, 0, 0, 0, 0, 0, 1, 5, 64'hCAFE_0001);
    rd("R8", 5); rd("R8", 8); rd("R8", 1); rd("R8", 31);
    // R10 ignored writes
    step("R10", 0, 0, 0, 0, 0, 0, 0, 1, 8, 64'hFFFF_FFFF);
    rd("R10", 8);
    step("R10", 0, 0, 0, 0, 0, 0, 0, 1, 7, 64'h1234);
    rd("R10", 7); rd("R10", 3); rd("R10", 2); rd("R10", 5); rd("R10", 6);
    // R11 count write wins, then increments
    step("R11", 0, 0, 0, 0, 0, 0, 0, 1, 4, 100);
    rd("R11", 4); rd("R11", 4);
    step("R11", 0, 0, 0, 0, 0, 0, 0, 1, 4, 64'hFFFF_FFFF);
    rd("R11", 4);
    // mixed random traffic
    for (int i = 0; i < 600; i++) begin
      longint unsigned a;
      int r = $urandom_range(0, 3);
      if (r == 0) a = $urandom_range(0, 64);
      else if (r == 1) a = MEM - $urandom_range(0, 16);
      else if (r == 2) a = {32'd0, $urandom()};
      else a = MEM + $urandom_range(0, 8);
      step("R8", $urandom_range(0, 1) == 1, a & 64'hFFFF_FFFF, $urandom_range(0, 3),
           $urandom_range(0, 3), $urandom_range(0, 5) == 0, $urandom_range(0, 31),
           {32'd0, $urandom()}, $urandom_range(0, 3) == 0, $urandom_range(0, 9),
           {32'd0, $urandom()});
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule